// File: doc/BRIEF.md
# Multi-Lane Video Line Framer

This block takes a raster of pixel words, marked by a frame-qualifier and a line-qualifier input, and re-sends it as a sync-coded word stream spread over one, two or four output lanes. Each completed line is held in a double-buffered line store. It is transmitted once the block knows whether that line was the last of its frame, which is either when the next line starts or when the frame qualifier drops. Every lane hands each word to its own shift-out stage, which sends it most significant bit first.

Two transfer modes exist. In packetized mode only pixel data is sent, and each line is wrapped in a leading and a trailing boundary code that mark the frame edges. In streaming mode each active line carries a leading code only. After a frame ends, a configured number of blanking lines follow, each with its own code and the same beat count as the active lines. Lane count, mode and blanking-line count can be changed only while the standby input is high.

Top module: `vfr_framer`

## Requirements
- R1: After reset no lane load strobe is raised, `cfg_err` and every serial output are 0, and the configuration is four lanes, streaming mode, one blanking line.
- R2: In packetized mode the leading code of the first line of a frame is the SOF value 1 and that of every later line is the SOL value 2; a code word is the 3-bit value in bits [2:0] with all upper bits zero.
- R3: In packetized mode the trailing code of the last line of a frame is the EOF value 5 and that of every other line is the EOL value 6, and nothing is sent for blanking.
- R4: In streaming mode every active line is preceded by code 2 and has no trailing code; after the frame qualifier falls, the configured number of blanking lines follows, each with code 4 and the same beat count as the last active line, all data words zero.
- R5: Pixel k of a line goes to lane k mod N, where lane code 0, 1, 2 selects N = 1, 2, 4; lanes at or above N never raise their load strobe.
- R6: When the line length is not a multiple of N, the last beat is filled with zero words on the lanes that have no pixel.
- R7: Every code is preceded on each active lane by one all-ones word and then two all-zero words, sent in the same beat on all active lanes.
- R8: A word loaded on a lane appears on that lane's serial output one bit per cycle, most significant bit first, starting the cycle after its load strobe.
- R9: A configuration write takes effect only while standby is high; the held configuration never changes while standby is low.
- R10: A write made while standby is low, or one with lane code 3, leaves the configuration unchanged and sets `cfg_err`, which stays set until reset.
- R11: While standby is high no lane raises its load strobe, and a line waiting for transmission is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| standby | input | 1 | Holds the block idle and opens the configuration |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_lanes | input | 2 | Lane code: 0 one lane, 1 two, 2 four |
| cfg_packet | input | 1 | 1 packetized mode, 0 streaming mode |
| cfg_vblank | input | VB_W | Blanking lines sent after a frame in streaming mode |
| fv | input | 1 | Frame qualifier |
| lv | input | 1 | Line qualifier, one pixel per cycle while high |
| pix | input | WORD_W | Pixel word |
| lane_word | output | NLANE*WORD_W | Last word loaded per lane, lane 0 in the low bits |
| lane_load | output | NLANE | One-cycle strobe per lane when a new word is loaded |
| lane_bit | output | NLANE | Serial output per lane |
| cfg_err | output | 1 | Sticky flag for a rejected configuration write |

## Verification
The assertions assume that the clock and reset are clean and that the stimulus keeps to the raster timing the block relies on. Lines are at least one pixel long. The frame qualifier is high around every line and falls only after the last line has ended. The gap between line starts is longer than the time needed to send one wrapped line. The directed stimulus leaves several hundred idle cycles after each line and a long tail after each frame, so no launch ever finds the sender busy. Configuration writes outside standby happen only in the scenarios meant to test their rejection.

// File: rtl/vfr_pkg.sv
package vfr_pkg;
  localparam int NLANE = 4;

  localparam logic [2:0] K_SOF = 3'd1;
  localparam logic [2:0] K_SOL = 3'd2;
  localparam logic [2:0] K_BLK = 3'd4;
  localparam logic [2:0] K_EOF = 3'd5;
  localparam logic [2:0] K_EOL = 3'd6;

  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_CODE, ST_DATA} emit_st_t;

  function automatic logic [NLANE-1:0] lane_mask(input logic [1:0] code);
    case (code)
      2'd0:    lane_mask = 4'b0001;
      2'd1:    lane_mask = 4'b0011;
      default: lane_mask = 4'b1111;
    endcase
  endfunction
endpackage

// File: rtl/vfr_linebuf.sv
module vfr_linebuf
  import vfr_pkg::*;
#(
  parameter int WORD_W   = 12,
  parameter int MAX_LINE = 64
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [1:0]              wbank,
  input  logic [$clog2(MAX_LINE/2)-1:0] waddr,
  input  logic [WORD_W-1:0]       wdata,
  input  logic [NLANE*$clog2(MAX_LINE/2)-1:0] raddr,
  output logic [NLANE*WORD_W-1:0] rdata
);
  localparam int DEPTH = MAX_LINE / 2;
  localparam int AW    = $clog2(DEPTH);

  for (genvar m = 0; m < NLANE; m++) begin : g_bank
    logic [WORD_W-1:0] mem [DEPTH];
    logic [WORD_W-1:0] rd_q;
    always_ff @(posedge clk) begin
      if (we && wbank == 2'(m)) mem[waddr] <= wdata;
      rd_q <= mem[raddr[m*AW +: AW]];
    end
    assign rdata[m*WORD_W +: WORD_W] = rd_q;
  end
endmodule

// File: rtl/vfr_serializer.sv
module vfr_serializer #(
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  output logic              bit_out
);
  logic [WORD_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst)       shreg <= '0;
    else if (load) shreg <= word;
    else           shreg <= {shreg[WORD_W-2:0], 1'b0};
  end

  assign bit_out = shreg[WORD_W-1];
endmodule

// File: rtl/vfr_emitter.sv
module vfr_emitter
  import vfr_pkg::*;
#(
  parameter int WORD_W    = 12,
  parameter int MAX_LINE  = 64,
  parameter int PRE_ZEROS = 2,
  parameter int VB_W      = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    hold,
  input  logic [1:0]              lanes_code,
  input  logic                    packet,
  input  logic [VB_W-1:0]         vblank,
  input  logic                    launch,
  input  logic                    l_sel,
  input  logic [$clog2(MAX_LINE+1)-1:0] l_len,
  input  logic                    l_first,
  input  logic                    l_last,
  input  logic [NLANE*WORD_W-1:0] rd_data,
  output logic                    idle,
  output logic [NLANE*$clog2(MAX_LINE/2)-1:0] rd_addr,
  output logic [NLANE-1:0]        lane_load,
  output logic [NLANE*WORD_W-1:0] lane_word
);
  localparam int LW = $clog2(MAX_LINE + 1);
  localparam int AW = $clog2(MAX_LINE / 2);
  localparam int CW = $clog2(PRE_ZEROS + 2);
  localparam int TW = $clog2(WORD_W);

  emit_st_t          st;
  logic [CW-1:0]     cnt;
  logic [LW-1:0]     beat, len;
  logic              sel, first, last, ending, blank;
  logic [VB_W-1:0]   blank_left;
  logic [TW-1:0]     tcnt;
  logic              tick;
  logic [NLANE-1:0]  mask;
  logic [LW:0]       span, nbeats;
  logic              last_beat;
  logic [LW+1:0]     base;
  logic [2:0]        kind;
  logic [WORD_W-1:0] code_word;
  logic [WORD_W-1:0] wnext [NLANE];
  logic [WORD_W-1:0] lw_q  [NLANE];

  assign tick      = (tcnt == TW'(WORD_W - 1));
  assign mask      = lane_mask(lanes_code);
  assign span      = (LW+1)'(1) << lanes_code;
  assign nbeats    = ({1'b0, len} + span - (LW+1)'(1)) >> lanes_code;
  assign last_beat = ({1'b0, beat} == nbeats - (LW+1)'(1));
  assign base      = {2'b00, beat} << lanes_code;
  assign idle      = (st == ST_IDLE);

  always_comb begin
    if (blank)        kind = K_BLK;
    else if (!packet) kind = K_SOL;
    else if (ending)  kind = last ? K_EOF : K_EOL;
    else              kind = first ? K_SOF : K_SOL;
  end
  assign code_word = {(WORD_W-3)'(0), kind};

  // bank m holds pixels p with p mod 4 == m; row is p / 4
  for (genvar m = 0; m < NLANE; m++) begin : g_raddr
    logic [AW-2:0] row;
    assign row = base[AW:2] + (AW-1)'(base[1:0] > 2'(m));
    assign rd_addr[m*AW +: AW] = {sel, row};
  end

  for (genvar j = 0; j < NLANE; j++) begin : g_lane
    logic [1:0]        bk;
    logic [LW+1:0]     kidx;
    logic              inr;
    logic [WORD_W-1:0] pixw;
    assign bk   = base[1:0] + 2'(j);
    assign kidx = base + (LW+2)'(j);
    assign inr  = kidx < {2'b00, len};
    assign pixw = rd_data[int'(bk)*WORD_W +: WORD_W];
    always_comb begin
      case (st)
        ST_PRE:  wnext[j] = (cnt == '0) ? '1 : '0;
        ST_CODE: wnext[j] = code_word;
        ST_DATA: wnext[j] = (!blank && inr) ? pixw : '0;
        default: wnext[j] = '0;
      endcase
    end
    assign lane_word[j*WORD_W +: WORD_W] = lw_q[j];
  end

  always_ff @(posedge clk) begin
    if (rst) tcnt <= '0;
    else     tcnt <= tick ? '0 : tcnt + TW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      st         <= ST_IDLE;
      cnt        <= '0;
      beat       <= '0;
      len        <= '0;
      sel        <= 1'b0;
      first      <= 1'b0;
      last       <= 1'b0;
      ending     <= 1'b0;
      blank      <= 1'b0;
      blank_left <= '0;
      lane_load  <= '0;
      for (int j = 0; j < NLANE; j++) lw_q[j] <= '0;
    end else begin
      lane_load <= '0;
      if (st == ST_IDLE) begin
        if (launch) begin
          st         <= ST_PRE;
          cnt        <= '0;
          beat       <= '0;
          sel        <= l_sel;
          len        <= l_len;
          first      <= l_first;
          last       <= l_last;
          ending     <= 1'b0;
          blank      <= 1'b0;
          blank_left <= (!packet && l_last) ? vblank : '0;
        end
      end else if (tick) begin
        lane_load <= mask;
        for (int j = 0; j < NLANE; j++)
          if (mask[j]) lw_q[j] <= wnext[j];
        case (st)
          ST_PRE: begin
            if (cnt == CW'(PRE_ZEROS)) st <= ST_CODE;
            else                       cnt <= cnt + CW'(1);
          end
          ST_CODE: begin
            if (ending) st <= ST_IDLE;
            else begin
              st   <= ST_DATA;
              beat <= '0;
            end
          end
          ST_DATA: begin
            if (!last_beat) beat <= beat + LW'(1);
            else if (packet) begin
              st     <= ST_PRE;
              cnt    <= '0;
              ending <= 1'b1;
            end else if (blank_left != '0) begin
              st         <= ST_PRE;
              cnt        <= '0;
              blank      <= 1'b1;
              blank_left <= blank_left - VB_W'(1);
            end else begin
              st <= ST_IDLE;
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/vfr_framer.sv
module vfr_framer
  import vfr_pkg::*;
#(
  parameter int WORD_W    = 12,
  parameter int MAX_LINE  = 64,
  parameter int PRE_ZEROS = 2,
  parameter int VB_W      = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    standby,
  input  logic                    cfg_we,
  input  logic [1:0]              cfg_lanes,
  input  logic                    cfg_packet,
  input  logic [VB_W-1:0]         cfg_vblank,
  input  logic                    fv,
  input  logic                    lv,
  input  logic [WORD_W-1:0]       pix,
  output logic [NLANE*WORD_W-1:0] lane_word,
  output logic [NLANE-1:0]        lane_load,
  output logic [NLANE-1:0]        lane_bit,
  output logic                    cfg_err
);
  localparam int LW = $clog2(MAX_LINE + 1);
  localparam int AW = $clog2(MAX_LINE / 2);

  // held configuration
  logic [1:0]      lanes_q;
  logic            packet_q;
  logic [VB_W-1:0] vblank_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lanes_q  <= 2'd2;
      packet_q <= 1'b0;
      vblank_q <= VB_W'(1);
      cfg_err  <= 1'b0;
    end else if (cfg_we) begin
      if (!standby || cfg_lanes == 2'd3) cfg_err <= 1'b1;
      else begin
        lanes_q  <= cfg_lanes;
        packet_q <= cfg_packet;
        vblank_q <= cfg_vblank;
      end
    end
  end

  // line capture into the ping-pong store
  logic          lv_q, fv_q, lv_fall, lv_rise, fv_fall;
  logic [LW-1:0] wr_idx, pend_len;
  logic          wsel, pend, pend_sel, pend_first, frame_first;
  logic          launch, em_idle, wr_en;

  assign lv_rise = lv && !lv_q;
  assign lv_fall = !lv && lv_q;
  assign fv_fall = !fv && fv_q;
  assign wr_en   = lv && !standby && (wr_idx < LW'(MAX_LINE));
  assign launch  = pend && em_idle && !standby && (lv_rise || fv_fall);

  always_ff @(posedge clk) begin
    if (rst) begin
      lv_q        <= 1'b0;
      fv_q        <= 1'b0;
      wr_idx      <= '0;
      wsel        <= 1'b0;
      pend        <= 1'b0;
      pend_sel    <= 1'b0;
      pend_len    <= '0;
      pend_first  <= 1'b0;
      frame_first <= 1'b1;
    end else begin
      lv_q <= lv;
      fv_q <= fv;
      if (standby) begin
        pend        <= 1'b0;
        wr_idx      <= '0;
        frame_first <= 1'b1;
      end else begin
        if (fv && !fv_q) frame_first <= 1'b1;
        if (lv && wr_idx != LW'(MAX_LINE)) wr_idx <= wr_idx + LW'(1);
        if (lv_fall) begin
          pend        <= 1'b1;
          pend_sel    <= wsel;
          pend_len    <= wr_idx;
          pend_first  <= frame_first;
          frame_first <= 1'b0;
          wsel        <= ~wsel;
          wr_idx      <= '0;
        end
        if (launch) pend <= 1'b0;
      end
    end
  end

  logic [NLANE*AW-1:0]     rd_addr;
  logic [NLANE*WORD_W-1:0] rd_data;

  vfr_linebuf #(.WORD_W(WORD_W), .MAX_LINE(MAX_LINE)) u_buf (
    .clk   (clk),
    .we    (wr_en),
    .wbank (wr_idx[1:0]),
    .waddr ({wsel, wr_idx[AW:2]}),
    .wdata (pix),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  vfr_emitter #(
    .WORD_W(WORD_W), .MAX_LINE(MAX_LINE), .PRE_ZEROS(PRE_ZEROS), .VB_W(VB_W)
  ) u_emit (
    .clk        (clk),
    .rst        (rst),
    .hold       (standby),
    .lanes_code (lanes_q),
    .packet     (packet_q),
    .vblank     (vblank_q),
    .launch     (launch),
    .l_sel      (pend_sel),
    .l_len      (pend_len),
    .l_first    (pend_first),
    .l_last     (fv_fall),
    .rd_data    (rd_data),
    .idle       (em_idle),
    .rd_addr    (rd_addr),
    .lane_load  (lane_load),
    .lane_word  (lane_word)
  );

  for (genvar j = 0; j < NLANE; j++) begin : g_ser
    vfr_serializer #(.WORD_W(WORD_W)) u_ser (
      .clk     (clk),
      .rst     (rst),
      .load    (lane_load[j]),
      .word    (lane_word[j*WORD_W +: WORD_W]),
      .bit_out (lane_bit[j])
    );
  end
endmodule

// File: rtl/vfr_framer_chk.sv
module vfr_framer_chk (
  input logic       clk,
  input logic       rst,
  input logic       standby,
  input logic       cfg_we,
  input logic       cfg_err,
  input logic [3:0] lane_load,
  input logic       bit0,
  input logic       w0_msb,
  input logic       w0_nxt,
  input logic [1:0] lanes_code,
  input logic       packet
);
  logic [3:0] exp_mask;
  assign exp_mask = 4'((5'd1 << (3'd1 << lanes_code)) - 5'd1);

  AST_LOAD_SHAPE: assert property (@(posedge clk) disable iff (rst)
    (lane_load != 4'b0) |-> (lane_load == exp_mask)); // R5
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !standby |=> ($stable(lanes_code) && $stable(packet))); // R9
  AST_ERR_ON_REJECT: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !standby) |=> cfg_err); // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> cfg_err); // R10
  AST_STANDBY_SILENT: assert property (@(posedge clk) disable iff (rst)
    standby |=> (lane_load == 4'b0)); // R11
  AST_SER_FIRST_BIT: assert property (@(posedge clk) disable iff (rst)
    lane_load[0] |=> (bit0 == $past(w0_msb))); // R8
  AST_SER_SECOND_BIT: assert property (@(posedge clk) disable iff (rst)
    lane_load[0] |-> ##2 (bit0 == $past(w0_nxt, 2))); // R8
endmodule

bind vfr_framer vfr_framer_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .standby    (standby),
  .cfg_we     (cfg_we),
  .cfg_err    (cfg_err),
  .lane_load  (lane_load),
  .bit0       (lane_bit[0]),
  .w0_msb     (lane_word[WORD_W-1]),
  .w0_nxt     (lane_word[WORD_W-2]),
  .lanes_code (lanes_q),
  .packet     (packet_q)
);

// File: tb/vfr_framer_test.sv
module vfr_framer_test;
  localparam int W    = 12;
  localparam int GAP  = 400;
  localparam int TAIL = 1500;
  localparam int QD   = 512;

  logic          clk = 0;
  logic          rst, standby, cfg_we, cfg_packet, fv, lv;
  logic [1:0]    cfg_lanes;
  logic [3:0]    cfg_vblank;
  logic [W-1:0]  pix;
  logic [4*W-1:0] lane_word;
  logic [3:0]    lane_load, lane_bit;
  logic          cfg_err;

  always #5 clk = ~clk;

  vfr_framer uut (
    .clk(clk), .rst(rst), .standby(standby), .cfg_we(cfg_we),
    .cfg_lanes(cfg_lanes), .cfg_packet(cfg_packet), .cfg_vblank(cfg_vblank),
    .fv(fv), .lv(lv), .pix(pix), .lane_word(lane_word),
    .lane_load(lane_load), .lane_bit(lane_bit), .cfg_err(cfg_err)
  );

  int npass = 0, nfail = 0;
  logic [W-1:0] got [4][QD];
  logic [W-1:0] exq [4][QD];
  int gcnt [4];
  int ecnt [4];
  int load_seen = 0;
  int ser_pos = 0;
  logic [W-1:0] ser_word;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    if (ok) npass++;
    else begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // capture lane words and check the serial stream of lane 0 (R8)
  always @(negedge clk) begin
    for (int j = 0; j < 4; j++)
      if (lane_load[j]) begin
        if (gcnt[j] < QD) got[j][gcnt[j]] = lane_word[j*W +: W];
        gcnt[j]++;
      end
    if (lane_load != 0) load_seen++;
    if (ser_pos > 0) begin
      ser_pos--;
      chk(lane_bit[0] == ser_word[ser_pos], "R8", "serial bit", lane_bit[0], ser_word[ser_pos]);
    end
    if (lane_load[0]) begin
      ser_word = lane_word[W-1:0];
      ser_pos  = W;
    end
  end

  task automatic clear_q();
    for (int j = 0; j < 4; j++) begin gcnt[j] = 0; ecnt[j] = 0; end
    load_seen = 0;
  endtask

  task automatic push(input int j, input int v);
    if (ecnt[j] < QD) exq[j][ecnt[j]] = W'(v);
    ecnt[j]++;
  endtask

  task automatic exp_sync(input int n, input int code);
    for (int j = 0; j < n; j++) begin
      push(j, 'hFFF); push(j, 0); push(j, 0); push(j, code);
    end
  endtask

  task automatic exp_data(input int n, input int len, input int base, input bit blank);
    for (int b = 0; b < (len + n - 1) / n; b++)
      for (int j = 0; j < n; j++)
        push(j, (!blank && (b*n + j) < len) ? base + b*n + j : 0);
  endtask

  task automatic compare(input string req);
    for (int j = 0; j < 4; j++) begin
      chk(gcnt[j] == ecnt[j], req, $sformatf("lane %0d word count", j), gcnt[j], ecnt[j]);
      for (int i = 0; i < ecnt[j] && i < gcnt[j] && i < QD; i++)
        chk(got[j][i] == exq[j][i], req, $sformatf("lane %0d word %0d", j, i), got[j][i], exq[j][i]);
    end
  endtask

  function automatic int line_base(input int l);
    return 'h100 + l * 32;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1; standby = 0; cfg_we = 0; cfg_lanes = 0; cfg_packet = 0;
    cfg_vblank = 0; fv = 0; lv = 0; pix = 0;
    repeat (5) @(negedge clk);
    rst = 0; ser_pos = 0;
    @(negedge clk);
  endtask

  task automatic write_cfg(input bit in_standby, input int lanes, input bit pkt, input int vb);
    standby = in_standby;
    @(negedge clk);
    cfg_we = 1; cfg_lanes = 2'(lanes); cfg_packet = pkt; cfg_vblank = 4'(vb);
    @(negedge clk);
    cfg_we = 0; standby = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_frame(input int nlines, input int len);
    fv = 1;
    repeat (3) @(negedge clk);
    for (int l = 0; l < nlines; l++) begin
      lv = 1;
      for (int k = 0; k < len; k++) begin
        pix = W'(line_base(l) + k);
        @(negedge clk);
      end
      lv = 0; pix = 0;
      repeat (GAP) @(negedge clk);
    end
    fv = 0;
    repeat (TAIL) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk(lane_load == 0, "R1", "load strobes after reset", lane_load, 0);
    chk(cfg_err == 0, "R1", "error flag after reset", cfg_err, 0);
    chk(lane_bit == 0, "R1", "serial outputs after reset", lane_bit, 0);
  endtask

  // R2 R3 R7: packetized, four lanes, three lines
  task automatic t_packet4();
    do_reset(); write_cfg(1, 2, 1, 0); clear_q();
    for (int l = 0; l < 3; l++) begin
      exp_sync(4, l == 0 ? 1 : 2);
      exp_data(4, 8, line_base(l), 0);
      exp_sync(4, l == 2 ? 5 : 6);
    end
    send_frame(3, 8);
    compare("R2/R3/R7 packetized four lanes");
  endtask

  // R5 R6: two lanes, odd length padded
  task automatic t_packet2_pad();
    do_reset(); write_cfg(1, 1, 1, 0); clear_q();
    for (int l = 0; l < 2; l++) begin
      exp_sync(2, l == 0 ? 1 : 2);
      exp_data(2, 5, line_base(l), 0);
      exp_sync(2, l == 1 ? 5 : 6);
    end
    send_frame(2, 5);
    compare("R5/R6 two lanes padded");
  endtask

  // R5: single lane
  task automatic t_packet1();
    do_reset(); write_cfg(1, 0, 1, 0); clear_q();
    for (int l = 0; l < 2; l++) begin
      exp_sync(1, l == 0 ? 1 : 2);
      exp_data(1, 3, line_base(l), 0);
      exp_sync(1, l == 1 ? 5 : 6);
    end
    send_frame(2, 3);
    compare("R5 single lane");
  endtask

  // R4 R6: streaming with two blanking lines
  task automatic t_stream();
    do_reset(); write_cfg(1, 2, 0, 2); clear_q();
    for (int l = 0; l < 2; l++) begin
      exp_sync(4, 2);
      exp_data(4, 6, line_base(l), 0);
    end
    for (int b = 0; b < 2; b++) begin
      exp_sync(4, 4);
      exp_data(4, 6, 0, 1);
    end
    send_frame(2, 6);
    compare("R4 streaming with blanking");
  endtask

  // R9 R10 R1: write outside standby is ignored, defaults stay
  task automatic t_reject_active();
    do_reset();
    write_cfg(0, 0, 1, 0);
    chk(cfg_err == 1, "R10", "error after write outside standby", cfg_err, 1);
    clear_q();
    exp_sync(4, 2); exp_data(4, 4, line_base(0), 0);
    exp_sync(4, 4); exp_data(4, 4, 0, 1);
    send_frame(1, 4);
    compare("R9/R1 default config kept");
    chk(cfg_err == 1, "R10", "error stays set", cfg_err, 1);
  endtask

  // R10: lane code 3 rejected even in standby
  task automatic t_reject_code();
    do_reset();
    write_cfg(1, 3, 1, 0);
    chk(cfg_err == 1, "R10", "error after lane code 3", cfg_err, 1);
    clear_q();
    exp_sync(4, 2); exp_data(4, 4, line_base(0), 0);
    exp_sync(4, 4); exp_data(4, 4, 0, 1);
    send_frame(1, 4);
    compare("R10 config unchanged after code 3");
  endtask

  // R11: standby silences lanes and drops the waiting line
  task automatic t_standby();
    int waited;
    do_reset(); write_cfg(1, 2, 1, 0); clear_q();
    fv = 1;
    repeat (3) @(negedge clk);
    for (int l = 0; l < 2; l++) begin
      lv = 1;
      for (int k = 0; k < 8; k++) begin pix = W'(line_base(l) + k); @(negedge clk); end
      lv = 0; pix = 0;
      repeat (4) @(negedge clk);
    end
    waited = 0;
    while (load_seen == 0 && waited < 200) begin @(negedge clk); waited++; end
    chk(load_seen != 0, "R11", "transmission started before standby", load_seen, 1);
    standby = 1;
    @(negedge clk);
    load_seen = 0;
    repeat (100) @(negedge clk);
    chk(load_seen == 0, "R11", "loads during standby", load_seen, 0);
    standby = 0;
    @(negedge clk);
    fv = 0;
    repeat (300) @(negedge clk);
    chk(load_seen == 0, "R11", "loads after release, waiting line dropped", load_seen, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("%0d/%0d checks passed", npass, npass + nfail);
    $finish;
  end

  initial begin
    rst = 1; standby = 0; cfg_we = 0; cfg_lanes = 0; cfg_packet = 0;
    cfg_vblank = 0; fv = 0; lv = 0; pix = 0;
    clear_q();
    t_reset();
    t_packet4();
    t_packet2_pad();
    t_packet1();
    t_stream();
    t_reject_active();
    t_reject_code();
    t_standby();
    $display("%0d/%0d checks passed", npass, npass + nfail);
    $finish;
  end
endmodule